// File: doc/BRIEF.md
# Multi-State Trigger Sequencer with Counter/Timers

This block is the decision core of a logic-capture trigger. A table of up to sixteen states is loaded through a simple write port. Each state holds two condition/action clauses. On every clock where a valid data sample is present and the sequencer is armed, the current state's clauses are tested in priority order. The first clause whose condition is true supplies the actions for that sample: jump to another state, fire the main trigger, pulse the signal-out or trigger-out line, pulse a request to reload a word recognizer, and issue a command to each of two 51-bit counter/timers.

Each counter/timer is set to one of two modes. In counter mode it steps up or down on command and saturates at zero and at 2^51-1. In timer mode it runs on every clock once started and holds once stopped. A clear command zeroes it at once and does not change whether it is running. A terminal flag from each counter/timer (count at or above its programmed limit) can be tested as a clause condition. An external trigger input fires the main trigger only while armed and not already triggered. The main trigger stays set until the next arm command.

Top module: `trig_seq`

## Requirements
- R1: After reset, trigMain, trigFromExt, sigOut, trigOut and reloadOut are 0, seqState is 0, ctrValue is 0, and the sequencer is not armed.
- R2: Clauses are evaluated only on clock edges where sampleValid is 1, the sequencer is armed, and arm is 0. On any other edge, seqState does not change and no action is taken.
- R3: A state table entry is written at progAddr equal to the state number, with clause 0 in progData[18:0] and clause 1 in progData[37:19]. Clause 0 is tested first, and clause 1 acts only when clause 0's condition is false. Clause bits, from MSB to LSB, are: cond[4], next state[4], jump, fire, signal, trigger-out, reload, op1[3], op0[3].
- R4: Condition codes 0 to 7 select recFlags[code]. Code 8 selects counter/timer 0's terminal flag and code 9 selects counter/timer 1's terminal flag. Code 10 is always true, and codes 11 to 15 are never true. When neither clause is true, the state is held.
- R5: The actions of a winning clause appear one clock after the sampling edge. With jump=1, seqState takes the next-state field. sigOut, trigOut and reloadOut are each high for exactly that one clock.
- R6: A clause with fire=1 sets trigMain, which then stays 1 until arm. Arm sets seqState to 0, clears trigMain and trigFromExt, zeroes and stops both counter/timers, and enables evaluation.
- R7: In counter mode, op code 1 adds one and op code 2 subtracts one. The count saturates at 2^51-1 and at 0.
- R8: In timer mode, op code 1 starts the timer and op code 2 stops it. While running, the count rises by one on every clock, whether or not a sample is present.
- R9: Op code 3 zeroes the count on that edge and keeps the timer's running or stopped state. Op code 4 loads the count with the programmed limit.
- R10: Counter/timer k is configured at progAddr 16+k, with its limit in progData[50:0] and timer mode in progData[51]. Its terminal flag is true while count >= limit.
- R11: extTrig sets trigMain, together with trigFromExt=1, only while the sequencer is armed and not yet triggered. It has no effect when unarmed or already triggered. If a clause fires on the same edge, the clause wins and trigFromExt stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Restart sequence and clear trigger |
| sampleValid | input | 1 | A valid data sample is present this clock |
| recFlags | input | 8 | Recognizer match flags for this sample |
| extTrig | input | 1 | External trigger request |
| progWe | input | 1 | Table write strobe |
| progAddr | input | 5 | Table address (states, then counter configs) |
| progData | input | 52 | Table write data |
| trigMain | output | 1 | Sticky main trigger |
| trigFromExt | output | 1 | Main trigger was caused by extTrig |
| sigOut | output | 1 | One-clock signal-out pulse |
| trigOut | output | 1 | One-clock trigger-out pulse |
| reloadOut | output | 1 | One-clock recognizer reload request |
| seqState | output | 4 | Current sequencer state |
| ctrValue | output | 102 | Counter/timer values, counter k at [51k+50:51k] |

## Verification
The checks assume that arm is a single-cycle pulse and that progWe is used only while no sample evaluation can change the table entry being read. The stimulus loads every table entry and counter configuration before the arm pulse that starts each scenario. Inputs change one time unit after a rising edge and are held until the next edge. Each sample is presented for exactly one clock, and idle clocks between samples exercise the no-evaluation rules.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int unsigned SEQ_STATES = 16;
  localparam int unsigned ST_W       = $clog2(SEQ_STATES);
  localparam int unsigned REC_N      = 8;
  localparam int unsigned CTR_N      = 2;
  localparam int unsigned CTR_W      = 51;
  localparam int unsigned COND_W     = 4;
  localparam int unsigned COND_N     = 1 << COND_W;
  localparam int unsigned COND_ALWAYS = REC_N + CTR_N;
  localparam int unsigned OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 3'd0,
    OP_UP   = 3'd1,
    OP_DOWN = 3'd2,
    OP_CLR  = 3'd3,
    OP_LOAD = 3'd4
  } ctrOp_e;

  typedef struct packed {
    logic [COND_W-1:0]          cond;
    logic [ST_W-1:0]            nextSt;
    logic                       jump;
    logic                       fire;
    logic                       sig;
    logic                       trg;
    logic                       reload;
    logic [CTR_N-1:0][OP_W-1:0] ops;
  } clause_t;

  localparam int unsigned CLAUSE_W = $bits(clause_t);
  localparam int unsigned ENTRY_W  = 2 * CLAUSE_W;
  localparam int unsigned PROG_W   = (ENTRY_W > CTR_W + 1) ? ENTRY_W : CTR_W + 1;
  localparam int unsigned ADDR_W   = $clog2(SEQ_STATES + CTR_N);

  typedef struct packed {
    logic                       clearAll;
    logic [CTR_N-1:0][OP_W-1:0] ops;
  } strobe_t;
endpackage

// File: rtl/trig_seq_ctr_unit.sv
module trig_seq_ctr_unit
  import trig_seq_pkg::*;
#(
  parameter int unsigned W = CTR_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clr,
  input  logic            cfgWe,
  input  logic [W:0]      cfgData,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    count,
  output logic            hit
);
  localparam logic [W-1:0] MAXV = '1;

  logic         timerMode;
  logic         run;
  logic [W-1:0] limit;
  logic [W-1:0] nxtCount;
  logic         nxtRun;
  ctrOp_e       opE;

  assign opE = ctrOp_e'(op);
  assign hit = (count >= limit);

  always_comb begin
    nxtCount = count;
    nxtRun   = run;
    unique case (opE)
      OP_CLR:  nxtCount = '0;
      OP_LOAD: nxtCount = limit;
      OP_UP: begin
        if (timerMode) nxtRun = 1'b1;
        else if (count != MAXV) nxtCount = count + 1'b1;
      end
      OP_DOWN: begin
        if (timerMode) nxtRun = 1'b0;
        else if (count != '0) nxtCount = count - 1'b1;
      end
      default: ;
    endcase
    if (timerMode && run && opE != OP_CLR && opE != OP_LOAD && count != MAXV)
      nxtCount = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      run       <= 1'b0;
      timerMode <= 1'b0;
      limit     <= '0;
    end else begin
      if (cfgWe) begin
        timerMode <= cfgData[W];
        limit     <= cfgData[W-1:0];
      end
      if (clr) begin
        count <= '0;
        run   <= 1'b0;
      end else begin
        count <= nxtCount;
        run   <= nxtRun;
      end
    end
  end
endmodule

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                dpCmd,
  input  logic                   progWe,
  input  logic [ADDR_W-1:0]      progAddr,
  input  logic [PROG_W-1:0]      progData,
  output logic [CTR_N*CTR_W-1:0] ctrValue,
  output logic [CTR_N-1:0]       ctrHit
);
  for (genvar k = 0; k < CTR_N; k++) begin : g_ctr
    logic cfgWe;
    assign cfgWe = progWe && (progAddr == ADDR_W'(SEQ_STATES + k));
    trig_seq_ctr_unit #(.W(CTR_W)) u_unit (
      .clk     (clk),
      .rstN    (rstN),
      .clr     (dpCmd.clearAll),
      .cfgWe   (cfgWe),
      .cfgData (progData[CTR_W:0]),
      .op      (dpCmd.ops[k]),
      .count   (ctrValue[k*CTR_W +: CTR_W]),
      .hit     (ctrHit[k])
    );
  end
endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic              sampleValid,
  input  logic [REC_N-1:0]  recFlags,
  input  logic              extTrig,
  input  logic [CTR_N-1:0]  ctrHit,
  input  logic              progWe,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [PROG_W-1:0] progData,
  output strobe_t           dpCmd,
  output logic              trigMain,
  output logic              trigFromExt,
  output logic              sigOut,
  output logic              trigOut,
  output logic              reloadOut,
  output logic [ST_W-1:0]   seqState
);
  clause_t tblLo [SEQ_STATES];
  clause_t tblHi [SEQ_STATES];

  for (genvar s = 0; s < SEQ_STATES; s++) begin : g_tbl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tblLo[s] <= '0;
        tblHi[s] <= '0;
      end else if (progWe && progAddr == ADDR_W'(s)) begin
        tblLo[s] <= clause_t'(progData[CLAUSE_W-1:0]);
        tblHi[s] <= clause_t'(progData[ENTRY_W-1:CLAUSE_W]);
      end
    end
  end

  logic              armed;
  logic [COND_N-1:0] condVec;
  clause_t           curLo, curHi, sel;
  logic              hitLo, hitHi, evalNow, act;

  always_comb begin
    condVec = '0;
    condVec[REC_N-1:0] = recFlags;
    condVec[REC_N +: CTR_N] = ctrHit;
    condVec[COND_ALWAYS] = 1'b1;
  end

  assign curLo   = tblLo[seqState];
  assign curHi   = tblHi[seqState];
  assign hitLo   = condVec[curLo.cond];
  assign hitHi   = condVec[curHi.cond];
  assign sel     = hitLo ? curLo : curHi;
  assign evalNow = armed && sampleValid && !arm;
  assign act     = evalNow && (hitLo || hitHi);

  assign dpCmd.clearAll = arm;
  assign dpCmd.ops      = act ? sel.ops : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed       <= 1'b0;
      seqState    <= '0;
      trigMain    <= 1'b0;
      trigFromExt <= 1'b0;
      sigOut      <= 1'b0;
      trigOut     <= 1'b0;
      reloadOut   <= 1'b0;
    end else if (arm) begin
      armed       <= 1'b1;
      seqState    <= '0;
      trigMain    <= 1'b0;
      trigFromExt <= 1'b0;
      sigOut      <= 1'b0;
      trigOut     <= 1'b0;
      reloadOut   <= 1'b0;
    end else begin
      sigOut    <= act && sel.sig;
      trigOut   <= act && sel.trg;
      reloadOut <= act && sel.reload;
      if (act && sel.jump) seqState <= sel.nextSt;
      if (armed && !trigMain) begin
        if (act && sel.fire) begin
          trigMain <= 1'b1;
        end else if (extTrig) begin
          trigMain    <= 1'b1;
          trigFromExt <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   arm,
  input  logic                   sampleValid,
  input  logic [REC_N-1:0]       recFlags,
  input  logic                   extTrig,
  input  logic                   progWe,
  input  logic [ADDR_W-1:0]      progAddr,
  input  logic [PROG_W-1:0]      progData,
  output logic                   trigMain,
  output logic                   trigFromExt,
  output logic                   sigOut,
  output logic                   trigOut,
  output logic                   reloadOut,
  output logic [ST_W-1:0]        seqState,
  output logic [CTR_N*CTR_W-1:0] ctrValue
);
  strobe_t          dpCmd;
  logic [CTR_N-1:0] ctrHit;

  trig_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .arm         (arm),
    .sampleValid (sampleValid),
    .recFlags    (recFlags),
    .extTrig     (extTrig),
    .ctrHit      (ctrHit),
    .progWe      (progWe),
    .progAddr    (progAddr),
    .progData    (progData),
    .dpCmd       (dpCmd),
    .trigMain    (trigMain),
    .trigFromExt (trigFromExt),
    .sigOut      (sigOut),
    .trigOut     (trigOut),
    .reloadOut   (reloadOut),
    .seqState    (seqState)
  );

  trig_seq_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCmd    (dpCmd),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .ctrValue (ctrValue),
    .ctrHit   (ctrHit)
  );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
  import trig_seq_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   arm,
  input logic                   sampleValid,
  input logic                   trigMain,
  input logic                   trigFromExt,
  input logic                   sigOut,
  input logic                   trigOut,
  input logic                   reloadOut,
  input logic [ST_W-1:0]        seqState,
  input logic [CTR_N*CTR_W-1:0] ctrValue
);
  AST_NO_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !arm) |=> $stable(seqState)); // R2
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> (!sigOut && !trigOut && !reloadOut)); // R5
  AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (trigMain && !arm) |=> trigMain); // R6
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!trigMain && seqState == '0 && ctrValue == '0)); // R6
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (trigMain && !arm) |=> $stable(trigFromExt)); // R11
  AST_SRC_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rstN)
    trigFromExt |-> trigMain); // R11
endmodule

bind trig_seq trig_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .arm         (arm),
  .sampleValid (sampleValid),
  .trigMain    (trigMain),
  .trigFromExt (trigFromExt),
  .sigOut      (sigOut),
  .trigOut     (trigOut),
  .reloadOut   (reloadOut),
  .seqState    (seqState),
  .ctrValue    (ctrValue)
);

// File: tb/trig_seq_bench.sv
module trig_seq_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CW = 51;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         arm = 1'b0;
  logic         sampleValid = 1'b0;
  logic [7:0]   recFlags = '0;
  logic         extTrig = 1'b0;
  logic         progWe = 1'b0;
  logic [4:0]   progAddr = '0;
  logic [51:0]  progData = '0;
  logic         trigMain, trigFromExt, sigOut, trigOut, reloadOut;
  logic [3:0]   seqState;
  logic [101:0] ctrValue;

  int nChecks = 0;
  int nFails  = 0;

  trig_seq u_trig_seq (
    .clk(clk), .rstN(rstN), .arm(arm), .sampleValid(sampleValid),
    .recFlags(recFlags), .extTrig(extTrig), .progWe(progWe),
    .progAddr(progAddr), .progData(progData), .trigMain(trigMain),
    .trigFromExt(trigFromExt), .sigOut(sigOut), .trigOut(trigOut),
    .reloadOut(reloadOut), .seqState(seqState), .ctrValue(ctrValue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic sample(logic [7:0] f);
    sampleValid = 1'b1;
    recFlags = f;
    step();
    sampleValid = 1'b0;
    recFlags = '0;
  endtask

  task automatic doArm();
    arm = 1'b1;
    step();
    arm = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [51:0] d);
    progWe = 1'b1;
    progAddr = a;
    progData = d;
    step();
    progWe = 1'b0;
  endtask

  function automatic logic [18:0] mk(int cond, int nxt, bit jump, bit fire,
                                     bit sig, bit trg, bit rel, int op0, int op1);
    return {cond[3:0], nxt[3:0], jump, fire, sig, trg, rel, op1[2:0], op0[2:0]};
  endfunction

  function automatic logic [51:0] ent(logic [18:0] c0, logic [18:0] c1);
    return {14'b0, c1, c0};
  endfunction

  function automatic logic [63:0] ctr(int k);
    return 64'(ctrValue[k*CW +: CW]);
  endfunction

  task automatic t_reset();
    check("R1 trigMain", trigMain, 0);
    check("R1 seqState", seqState, 0);
    check("R1 ctr0", ctr(0), 0);
    check("R1 ctr1", ctr(1), 0);
    check("R1 pulses", {sigOut, trigOut, reloadOut, trigFromExt}, 0);
  endtask

  task automatic t_ext_unarmed();
    extTrig = 1'b1;
    step();
    extTrig = 1'b0;
    check("R11 unarmed ext ignored", trigMain, 0);
  endtask

  task automatic t_sequence();
    wr(0, ent(mk(1, 1, 1, 0, 1, 0, 0, 0, 0), mk(2, 2, 1, 0, 0, 1, 0, 0, 0)));
    wr(1, ent(mk(10, 3, 1, 0, 0, 0, 1, 0, 0), mk(12, 0, 1, 0, 0, 0, 0, 0, 0)));
    wr(3, ent(mk(5, 4, 1, 1, 0, 0, 0, 0, 0), mk(12, 0, 1, 0, 0, 0, 0, 0, 0)));
    doArm();
    recFlags = 8'h02;
    step();
    recFlags = '0;
    check("R2 no sample, state held", seqState, 0);
    check("R2 no sample, no pulse", sigOut, 0);
    sample(8'h06);
    check("R3 clause0 wins state", seqState, 1);
    check("R3 clause0 wins sigOut", sigOut, 1);
    check("R3 clause1 suppressed", trigOut, 0);
    step();
    check("R5 sigOut one clock", sigOut, 0);
    sample(8'h00);
    check("R4 always cond state", seqState, 3);
    check("R5 reload pulse", reloadOut, 1);
    sample(8'h00);
    check("R4 no clause true holds", seqState, 3);
    check("R4 never cond no trig", trigMain, 0);
    sample(8'h20);
    check("R4 rec5 cond state", seqState, 4);
    check("R6 fire sets trig", trigMain, 1);
    check("R11 seq source", trigFromExt, 0);
    extTrig = 1'b1;
    step();
    extTrig = 1'b0;
    check("R11 ext after trig ignored", trigFromExt, 0);
    step(5);
    check("R6 trig sticky", trigMain, 1);
    doArm();
    check("R6 arm clears trig", trigMain, 0);
    check("R6 arm state zero", seqState, 0);
    sample(8'h04);
    check("R3 clause1 state", seqState, 2);
    check("R3 clause1 trigOut", trigOut, 1);
    check("R3 clause1 no sigOut", sigOut, 0);
  endtask

  task automatic t_ext();
    doArm();
    extTrig = 1'b1;
    step();
    extTrig = 1'b0;
    check("R11 ext trig fires", trigMain, 1);
    check("R11 ext source flag", trigFromExt, 1);
  endtask

  task automatic t_counter();
    wr(16, {1'b0, 51'd3});
    wr(17, {1'b0, {CW{1'b1}}});
    wr(0, ent(mk(8, 6, 1, 1, 0, 0, 0, 0, 0), mk(10, 0, 0, 0, 0, 0, 0, 1, 0)));
    wr(6, ent(mk(0, 0, 0, 0, 0, 0, 0, 2, 0), mk(1, 7, 1, 0, 0, 0, 0, 0, 0)));
    wr(7, ent(mk(0, 0, 0, 0, 0, 0, 0, 0, 4), mk(1, 0, 0, 0, 0, 0, 0, 0, 1)));
    doArm();
    sample(8'h00);
    check("R7 inc 1", ctr(0), 1);
    sample(8'h00);
    sample(8'h00);
    check("R10 below limit no hit", seqState, 0);
    check("R7 inc 3", ctr(0), 3);
    sample(8'h00);
    check("R10 terminal hit state", seqState, 6);
    check("R10 terminal fires", trigMain, 1);
    check("R10 count unchanged", ctr(0), 3);
    sample(8'h01);
    check("R7 dec", ctr(0), 2);
    sample(8'h01);
    sample(8'h01);
    sample(8'h01);
    check("R7 floor at zero", ctr(0), 0);
    sample(8'h02);
    check("R4 goto 7", seqState, 7);
    sample(8'h01);
    check("R9 load limit", ctr(1), {13'b0, {CW{1'b1}}});
    sample(8'h02);
    check("R7 ceiling at max", ctr(1), {13'b0, {CW{1'b1}}});
  endtask

  task automatic t_timer();
    wr(17, {1'b1, 51'd100});
    wr(0, ent(mk(0, 1, 1, 0, 0, 0, 0, 0, 1), 19'd0));
    wr(1, ent(mk(0, 0, 0, 0, 0, 0, 0, 0, 3), mk(1, 2, 1, 0, 0, 0, 0, 0, 2)));
    wr(2, ent(mk(0, 0, 0, 0, 0, 0, 0, 0, 3), 19'd0));
    doArm();
    check("R6 arm zeroes ctr1", ctr(1), 0);
    sample(8'h01);
    check("R8 start edge", ctr(1), 0);
    step(5);
    check("R8 running counts clocks", ctr(1), 5);
    sample(8'h01);
    check("R9 clear zeroes", ctr(1), 0);
    step(3);
    check("R9 clear keeps running", ctr(1), 3);
    sample(8'h02);
    check("R8 stop edge", ctr(1), 4);
    step(4);
    check("R8 stopped holds", ctr(1), 4);
    sample(8'h01);
    step(3);
    check("R9 clear keeps stopped", ctr(1), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step();
    t_reset();
    t_ext_unarmed();
    t_sequence();
    t_ext();
    t_counter();
    t_timer();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule